// File: doc/BRIEF.md
# Load Issue Gate with Store-Wait Prediction

This block sits beside the memory pipeline of an out-of-order core and decides, each cycle, whether a load that is otherwise ready may be sent to execute while older stores are still uncommitted. It holds the older stores in a program-ordered address queue, where each entry's address is either still pending or already resolved. It also holds a one-bit-per-entry prediction table, indexed by the load's instruction address. A load whose bit is clear is sent speculatively, even when the address of an older store is still pending. A load whose bit is set waits until no older store remains in the queue.

Each load that is sent is recorded together with its age and the low address bits. When a store address resolves, it is compared in the same cycle against every recorded load younger than that store. On a match the gate pulses a squash that carries the age of the oldest offending load. It discards that load's record and the records of all younger loads, and it sets the prediction bit for that load's instruction address. A free-running counter wipes the whole table once per period, so loads that alias only now and then get back to speculating. The flush itself and store-to-load data forwarding belong to neighbouring logic.

Top module: `load_issue_gate`

## Requirements
- R1: After reset the store queue is empty (`st_full_o`=0), `squash_o` is 0 and every prediction bit is clear, so a load request with no older store gets `ld_go_o`=1 in the same cycle.
- R2: A load whose prediction bit is clear gets `ld_go_o`=1 while older stores with pending addresses exist, provided that no resolved older store matches it.
- R3: A load is held (`ld_go_o`=0) when an older store with a resolved address has the same address bits [11:0]. This holds even if the higher bits differ. A difference in bits [11:0] does not hold the load.
- R4: A load whose prediction bit is set is held while any store older than it is in the queue. It gets `ld_go_o`=1 once all older stores have completed. Younger stores do not hold it.
- R5: When a store address resolves at a clock edge and matches bits [11:0] of a recorded load younger than that store, `squash_o` is 1 for exactly the following cycle. Ages compare modulo 2^8: a is older than b when bit 7 of (a-b) is 1.
- R6: When several recorded loads match at once, `squash_age_o` gives the oldest of them.
- R7: A squash sets the prediction bit selected by the offending load's instruction address bits [7:2]. Later requests whose address has the same bits [7:2] are treated as predicted. Other indices are not affected.
- R8: All prediction bits clear at every CLR_PERIOD-th clock edge after reset is released. A set request at the same edge wins.
- R9: A squash discards the records of the offending load and every younger load, so a later store resolve that matches only those loads gives no squash.
- R10: `ld_go_o` is 0 in any cycle in which a store address resolves, and also while all LT_DEPTH load records are in use. A record is freed one edge after no older store remains.
- R11: `st_full_o` is 1 while SQ_DEPTH stores are in the queue. A store completion, which removes the oldest entry, clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| st_alloc_i | input | 1 | Append a store (address pending) at the queue tail |
| st_age_i | input | 8 | Age of the store being appended |
| st_idx_o | output | log2(SQ_DEPTH) | Queue slot that the append uses |
| st_full_o | output | 1 | Queue holds SQ_DEPTH stores |
| st_res_i | input | 1 | A store address resolves this cycle |
| st_res_idx_i | input | log2(SQ_DEPTH) | Queue slot of the resolving store |
| st_res_addr_i | input | ADDR_W | Resolved store address |
| st_done_i | input | 1 | The oldest store completes and leaves the queue |
| ld_req_i | input | 1 | A ready load asks to execute |
| ld_pc_i | input | PC_W | Instruction address of the load |
| ld_age_i | input | 8 | Age of the load |
| ld_addr_i | input | ADDR_W | Load address |
| ld_go_o | output | 1 | Load may execute now; it is recorded at this edge |
| squash_o | output | 1 | One-cycle ordering-violation pulse |
| squash_age_o | output | 8 | Age of the oldest violating load |

## Verification
`ld_go_o` is combinational, so the bench drives a request just after a falling edge and samples the grant 1 ns later, before the rising edge that records the load. `squash_o` and `squash_age_o` come from registers loaded at the edge that sees the resolve. They are read at the next falling edge, and one cycle later to confirm that the pulse is a single cycle. A prediction bit set by a squash takes effect at that same edge, so a request in the very next cycle is already held. The periodic wipe is checked by aligning to a counter of edges since reset that the bench keeps itself, with the set placed well away from a wipe edge. Freed load records are tested one idle cycle after the last older store leaves.

// File: rtl/lsg_pkg.sv
package lsg_pkg;
  localparam int unsigned AGE_W = 8;
  localparam int unsigned PA_W  = 12;

  typedef logic [AGE_W-1:0] age_t;
  typedef logic [PA_W-1:0]  paddr_t;

  // a strictly older than b, modulo wrap
  function automatic logic age_older(input age_t a, input age_t b);
    age_t d;
    d = a - b;
    return d[AGE_W-1];
  endfunction
endpackage

// File: rtl/lsg_store_queue.sv
module lsg_store_queue
  import lsg_pkg::*;
#(
  parameter  int unsigned DEPTH = 16,
  localparam int unsigned IW    = $clog2(DEPTH)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                alloc_i,
  input  age_t                alloc_age_i,
  output logic [IW-1:0]       alloc_idx_o,
  output logic                full_o,
  output logic                empty_o,
  input  logic                res_i,
  input  logic [IW-1:0]       res_idx_i,
  input  paddr_t              res_paddr_i,
  output age_t                res_age_o,
  input  logic                pop_i,
  output logic [DEPTH-1:0]    vld_o,
  output logic [DEPTH-1:0]    known_o,
  output age_t [DEPTH-1:0]    age_o,
  output paddr_t [DEPTH-1:0]  paddr_o
);
  logic [IW:0]          head_q, tail_q;
  logic [DEPTH-1:0]     vld_q, known_q;
  age_t [DEPTH-1:0]     age_q;
  paddr_t [DEPTH-1:0]   paddr_q;

  assign full_o      = (head_q[IW] != tail_q[IW]) && (head_q[IW-1:0] == tail_q[IW-1:0]);
  assign empty_o     = (head_q == tail_q);
  assign alloc_idx_o = tail_q[IW-1:0];
  assign res_age_o   = age_q[res_idx_i];
  assign vld_o       = vld_q;
  assign known_o     = known_q;
  assign age_o       = age_q;
  assign paddr_o     = paddr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      head_q  <= '0;
      tail_q  <= '0;
      vld_q   <= '0;
      known_q <= '0;
      age_q   <= '0;
      paddr_q <= '0;
    end else begin
      if (alloc_i) begin
        vld_q[tail_q[IW-1:0]]   <= 1'b1;
        known_q[tail_q[IW-1:0]] <= 1'b0;
        age_q[tail_q[IW-1:0]]   <= alloc_age_i;
        tail_q                  <= tail_q + 1'b1;
      end
      if (res_i) begin
        known_q[res_idx_i] <= 1'b1;
        paddr_q[res_idx_i] <= res_paddr_i;
      end
      if (pop_i) begin
        vld_q[head_q[IW-1:0]] <= 1'b0;
        head_q                <= head_q + 1'b1;
      end
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alloc_i |-> !full_o); // R11
  AST_NO_UNDERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> !empty_o); // R11
  AST_RES_LIVE_SLOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_i |-> vld_q[res_idx_i]); // R5
endmodule

// File: rtl/lsg_load_table.sv
module lsg_load_table
  import lsg_pkg::*;
#(
  parameter int unsigned DEPTH    = 8,
  parameter int unsigned SQ_DEPTH = 16,
  parameter int unsigned PCI_W    = 6
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  ins_i,
  input  age_t                  ins_age_i,
  input  paddr_t                ins_paddr_i,
  input  logic [PCI_W-1:0]      ins_pci_i,
  output logic                  full_o,
  input  logic                  chk_i,
  input  age_t                  chk_age_i,
  input  paddr_t                chk_paddr_i,
  output logic                  hit_o,
  output age_t                  hit_age_o,
  output logic [PCI_W-1:0]      hit_pci_o,
  input  logic [SQ_DEPTH-1:0]   sq_vld_i,
  input  age_t [SQ_DEPTH-1:0]   sq_age_i
);
  logic [DEPTH-1:0]             vld_q;
  age_t [DEPTH-1:0]             age_q;
  paddr_t [DEPTH-1:0]           pa_q;
  logic [DEPTH-1:0][PCI_W-1:0]  pci_q;

  logic [DEPTH-1:0] match, kill, retire, slot_oh;

  // per-entry violation match and retirement (no older store left)
  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      match[i]  = chk_i && vld_q[i] && age_older(chk_age_i, age_q[i]) &&
                  (pa_q[i] == chk_paddr_i);
      retire[i] = vld_q[i];
      for (int j = 0; j < SQ_DEPTH; j++) begin
        if (sq_vld_i[j] && age_older(sq_age_i[j], age_q[i])) retire[i] = 1'b0;
      end
    end
  end

  // oldest matching load
  always_comb begin
    logic found;
    age_t best_age;
    logic [PCI_W-1:0] best_pci;
    found    = 1'b0;
    best_age = '0;
    best_pci = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (match[i] && (!found || age_older(age_q[i], best_age))) begin
        found    = 1'b1;
        best_age = age_q[i];
        best_pci = pci_q[i];
      end
    end
    hit_o     = found;
    hit_age_o = best_age;
    hit_pci_o = best_pci;
  end

  // squash drops the offender and everything younger
  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      kill[i] = hit_o && vld_q[i] && !age_older(age_q[i], hit_age_o);
    end
  end

  // first free slot
  always_comb begin
    logic taken;
    taken   = 1'b0;
    slot_oh = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (!vld_q[i] && !taken) begin
        slot_oh[i] = 1'b1;
        taken      = 1'b1;
      end
    end
  end

  assign full_o = &vld_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= '0;
      age_q <= '0;
      pa_q  <= '0;
      pci_q <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (retire[i] || kill[i]) begin
          vld_q[i] <= 1'b0;
        end else if (ins_i && slot_oh[i]) begin
          vld_q[i] <= 1'b1;
          age_q[i] <= ins_age_i;
          pa_q[i]  <= ins_paddr_i;
          pci_q[i] <= ins_pci_i;
        end
      end
    end
  end

  AST_LT_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ins_i |-> !full_o); // R10
  AST_HIT_NEEDS_CHECK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> chk_i); // R5
  AST_KILL_EMPTIES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |=> $countones(vld_q) < DEPTH); // R9
endmodule

// File: rtl/lsg_wait_pred.sv
module lsg_wait_pred #(
  parameter  int unsigned ENTRIES    = 64,
  parameter  int unsigned CLR_PERIOD = 4096,
  localparam int unsigned IW         = $clog2(ENTRIES),
  localparam int unsigned CW         = $clog2(CLR_PERIOD)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [IW-1:0] lk_idx_i,
  output logic          lk_bit_o,
  input  logic          set_i,
  input  logic [IW-1:0] set_idx_i
);
  logic [ENTRIES-1:0] tbl_q;
  logic [CW-1:0]      cnt_q;
  logic               clr;

  assign clr      = (cnt_q == CW'(CLR_PERIOD - 1));
  assign lk_bit_o = tbl_q[lk_idx_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      tbl_q <= '0;
    end else begin
      cnt_q <= clr ? '0 : cnt_q + 1'b1;
      if (clr) tbl_q <= '0;
      if (set_i) tbl_q[set_idx_i] <= 1'b1;  // set wins over wipe
    end
  end

  AST_SET_STICKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> tbl_q[$past(set_idx_i)]); // R7
  AST_PERIOD_WIPE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr && !set_i) |=> (tbl_q == '0)); // R8
endmodule

// File: rtl/load_issue_gate.sv
module load_issue_gate
  import lsg_pkg::*;
#(
  parameter  int unsigned SQ_DEPTH   = 16,
  parameter  int unsigned LT_DEPTH   = 8,
  parameter  int unsigned WT_ENTRIES = 64,
  parameter  int unsigned CLR_PERIOD = 4096,
  parameter  int unsigned PC_W       = 32,
  parameter  int unsigned ADDR_W     = 32,
  localparam int unsigned SQ_IW      = $clog2(SQ_DEPTH),
  localparam int unsigned WT_IW      = $clog2(WT_ENTRIES)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                st_alloc_i,
  input  logic [AGE_W-1:0]    st_age_i,
  output logic [SQ_IW-1:0]    st_idx_o,
  output logic                st_full_o,
  input  logic                st_res_i,
  input  logic [SQ_IW-1:0]    st_res_idx_i,
  input  logic [ADDR_W-1:0]   st_res_addr_i,
  input  logic                st_done_i,
  input  logic                ld_req_i,
  input  logic [PC_W-1:0]     ld_pc_i,
  input  logic [AGE_W-1:0]    ld_age_i,
  input  logic [ADDR_W-1:0]   ld_addr_i,
  output logic                ld_go_o,
  output logic                squash_o,
  output logic [AGE_W-1:0]    squash_age_o
);
  logic [SQ_DEPTH-1:0]  sq_vld, sq_known;
  age_t [SQ_DEPTH-1:0]  sq_age;
  paddr_t [SQ_DEPTH-1:0] sq_pa;
  logic                 sq_empty;
  age_t                 res_age;

  logic                 lt_full, hit;
  age_t                 hit_age;
  logic [WT_IW-1:0]     hit_pci, ld_pci;
  logic                 wait_bit;
  logic                 blk_any, blk_match;
  paddr_t               ld_pa;

  assign ld_pci = ld_pc_i[WT_IW+1:2];
  assign ld_pa  = ld_addr_i[PA_W-1:0];

  lsg_store_queue #(.DEPTH(SQ_DEPTH)) u_sq (
    .clk_i, .rst_ni,
    .alloc_i     (st_alloc_i),
    .alloc_age_i (st_age_i),
    .alloc_idx_o (st_idx_o),
    .full_o      (st_full_o),
    .empty_o     (sq_empty),
    .res_i       (st_res_i),
    .res_idx_i   (st_res_idx_i),
    .res_paddr_i (st_res_addr_i[PA_W-1:0]),
    .res_age_o   (res_age),
    .pop_i       (st_done_i),
    .vld_o       (sq_vld),
    .known_o     (sq_known),
    .age_o       (sq_age),
    .paddr_o     (sq_pa)
  );

  lsg_load_table #(.DEPTH(LT_DEPTH), .SQ_DEPTH(SQ_DEPTH), .PCI_W(WT_IW)) u_lt (
    .clk_i, .rst_ni,
    .ins_i       (ld_go_o),
    .ins_age_i   (ld_age_i),
    .ins_paddr_i (ld_pa),
    .ins_pci_i   (ld_pci),
    .full_o      (lt_full),
    .chk_i       (st_res_i),
    .chk_age_i   (res_age),
    .chk_paddr_i (st_res_addr_i[PA_W-1:0]),
    .hit_o       (hit),
    .hit_age_o   (hit_age),
    .hit_pci_o   (hit_pci),
    .sq_vld_i    (sq_vld),
    .sq_age_i    (sq_age)
  );

  lsg_wait_pred #(.ENTRIES(WT_ENTRIES), .CLR_PERIOD(CLR_PERIOD)) u_wp (
    .clk_i, .rst_ni,
    .lk_idx_i  (ld_pci),
    .lk_bit_o  (wait_bit),
    .set_i     (hit),
    .set_idx_i (hit_pci)
  );

  // older-store scan for the requesting load
  always_comb begin
    blk_any   = 1'b0;
    blk_match = 1'b0;
    for (int j = 0; j < SQ_DEPTH; j++) begin
      if (sq_vld[j] && age_older(sq_age[j], ld_age_i)) begin
        blk_any = 1'b1;
        if (sq_known[j] && (sq_pa[j] == ld_pa)) blk_match = 1'b1;
      end
    end
  end

  // resolve cycle holds loads so a fresh record never misses its check
  assign ld_go_o = ld_req_i && !st_res_i && !lt_full &&
                   (wait_bit ? !blk_any : !blk_match);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      squash_o     <= 1'b0;
      squash_age_o <= '0;
    end else begin
      squash_o     <= hit;
      squash_age_o <= hit ? hit_age : squash_age_o;
    end
  end

  AST_SQUASH_FROM_RESOLVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    squash_o |-> $past(st_res_i)); // R5
  AST_EMPTY_NO_SQUASH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sq_empty && !st_res_i) |=> !squash_o); // R5
endmodule

// File: tb/load_issue_gate_bench.sv
module load_issue_gate_bench;
  localparam int unsigned CLRP = 256;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        st_alloc = 1'b0;
  logic [7:0]  st_age = '0;
  logic [3:0]  st_idx;
  logic        st_full;
  logic        st_res = 1'b0;
  logic [3:0]  st_res_idx = '0;
  logic [31:0] st_res_addr = '0;
  logic        st_done = 1'b0;
  logic        ld_req = 1'b0;
  logic [31:0] ld_pc = '0;
  logic [7:0]  ld_age = '0;
  logic [31:0] ld_addr = '0;
  logic        ld_go;
  logic        squash;
  logic [7:0]  squash_age;

  int n_chk = 0;
  int n_err = 0;
  int cyc = 0;

  always #2 clk = ~clk;

  always @(posedge clk or negedge rst_n)
    if (!rst_n) cyc <= 0; else cyc <= cyc + 1;

  load_issue_gate #(.CLR_PERIOD(CLRP)) u_load_issue_gate (
    .clk_i(clk), .rst_ni(rst_n),
    .st_alloc_i(st_alloc), .st_age_i(st_age), .st_idx_o(st_idx), .st_full_o(st_full),
    .st_res_i(st_res), .st_res_idx_i(st_res_idx), .st_res_addr_i(st_res_addr),
    .st_done_i(st_done),
    .ld_req_i(ld_req), .ld_pc_i(ld_pc), .ld_age_i(ld_age), .ld_addr_i(ld_addr),
    .ld_go_o(ld_go), .squash_o(squash), .squash_age_o(squash_age)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic alloc(input int age, output int idx);
    st_alloc = 1'b1; st_age = 8'(age);
    #1 idx = int'(st_idx);
    @(posedge clk); @(negedge clk);
    st_alloc = 1'b0;
  endtask

  task automatic resolve(input int idx, input logic [31:0] addr);
    st_res = 1'b1; st_res_idx = 4'(idx); st_res_addr = addr;
    @(posedge clk); @(negedge clk);
    st_res = 1'b0;
  endtask

  task automatic done_st();
    st_done = 1'b1;
    @(posedge clk); @(negedge clk);
    st_done = 1'b0;
  endtask

  task automatic load_q(input logic [31:0] pc, input int age, input logic [31:0] addr,
                        output int go);
    ld_req = 1'b1; ld_pc = pc; ld_age = 8'(age); ld_addr = addr;
    #1 go = int'(ld_go);
    @(posedge clk); @(negedge clk);
    ld_req = 1'b0;
  endtask

  task automatic resolve_with_load(input int idx, input logic [31:0] saddr,
                                   input logic [31:0] pc, input int age,
                                   input logic [31:0] laddr, output int go);
    st_res = 1'b1; st_res_idx = 4'(idx); st_res_addr = saddr;
    ld_req = 1'b1; ld_pc = pc; ld_age = 8'(age); ld_addr = laddr;
    #1 go = int'(ld_go);
    @(posedge clk); @(negedge clk);
    st_res = 1'b0; ld_req = 1'b0;
  endtask

  task automatic wait_phase(input int ph);
    while ((cyc % CLRP) != ph) @(negedge clk);
  endtask

  // expected grant for a clear-bit load over resolved stores
  function automatic int exp_go_rand(input logic [11:0] st_lo[4], input int r,
                                     input logic [11:0] ld_lo);
    int g = 1;
    for (int j = 0; j <= r; j++) if (st_lo[j] == ld_lo) g = 0;
    return g;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    n_err++;
    $display("FAIL R1 watchdog act=timeout exp=finish");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    int go, i0, i1, i2, i3, seed;
    logic [11:0] pool[3];
    logic [11:0] st_lo[4];
    int sidx[4];
    seed = 7;
    void'($urandom(seed));
    pool[0] = 12'h040; pool[1] = 12'h080; pool[2] = 12'h0C0;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // reset state
    chk("R1 queue not full", int'(st_full), 0);
    chk("R1 no squash", int'(squash), 0);
    load_q(32'h0000_0100, 1, 32'h0000_0040, go);
    chk("R1 load with empty queue", go, 1);

    // random: resolved stores, clear-bit loads
    for (int rnd = 0; rnd < 20; rnd++) begin
      int base = (rnd * 16 + 8) & 8'hff;
      for (int j = 0; j < 4; j++) begin
        st_lo[j] = pool[$urandom % 3];
        alloc(base + 2 * j, sidx[j]);
      end
      for (int j = 0; j < 4; j++) resolve(sidx[j], {$urandom % 20'hFFFFF, st_lo[j]});
      for (int k = 0; k < 6; k++) begin
        int r = $urandom % 4;
        logic [11:0] lo = pool[$urandom % 3];
        load_q($urandom & 32'hFFFF_FFFC, base + 2 * r + 1, {$urandom % 20'hFFFFF, lo}, go);
        chk("R3 random partial-address gate", go, exp_go_rand(st_lo, r, lo));
      end
      for (int j = 0; j < 4; j++) done_st();
      @(negedge clk);
    end

    // queue full
    for (int k = 0; k < 16; k++) begin
      if (k == 15) chk("R11 not full at depth-1", int'(st_full), 0);
      alloc(k, i0);
    end
    chk("R11 full at depth", int'(st_full), 1);
    done_st();
    chk("R11 completion clears full", int'(st_full), 0);
    for (int k = 0; k < 15; k++) done_st();
    @(negedge clk);

    // speculation past pending store, partial compare, resolve-cycle hold
    alloc(20, i0);
    load_q(32'h0000_0600, 21, 32'h0000_0100, go);
    chk("R2 speculate past pending store", go, 1);
    resolve_with_load(i0, 32'h0000_5040, 32'h0000_0604, 22, 32'h0000_0777, go);
    chk("R10 held during resolve", go, 0);
    chk("R5 no squash without match", int'(squash), 0);
    load_q(32'h0000_0604, 23, 32'hABCD_E040, go);
    chk("R3 low-12 match holds", go, 0);
    load_q(32'h0000_0604, 23, 32'h0000_5044, go);
    chk("R3 low-12 differ goes", go, 1);
    done_st();
    @(negedge clk);

    // violation, oldest report, kill, learn
    wait_phase(8);
    alloc(40, i1);
    alloc(41, i2);
    load_q(32'h0000_0408, 42, 32'h0000_1080, go);
    chk("R2 load 42 speculates", go, 1);
    load_q(32'h0000_0410, 43, 32'h0000_20C0, go);
    chk("R2 load 43 speculates", go, 1);
    load_q(32'h0000_040C, 44, 32'h0003_3080, go);
    chk("R2 load 44 speculates", go, 1);
    resolve(i1, 32'h0000_9080);
    chk("R5 squash pulse", int'(squash), 1);
    chk("R6 oldest violator age", int'(squash_age), 42);
    @(negedge clk);
    chk("R5 squash lasts one cycle", int'(squash), 0);
    resolve(i2, 32'h0000_20C0);
    chk("R9 killed load gives no squash", int'(squash), 0);
    load_q(32'h0000_0408, 45, 32'h0000_3100, go);
    chk("R7 learned load held", go, 0);
    load_q(32'h0000_0508, 45, 32'h0000_3100, go);
    chk("R7 same index bits held", go, 0);
    load_q(32'h0000_0410, 45, 32'h0000_3100, go);
    chk("R7 other index unaffected", go, 1);
    done_st();
    load_q(32'h0000_0408, 45, 32'h0000_3100, go);
    chk("R4 held while one older store left", go, 0);
    done_st();
    load_q(32'h0000_0408, 45, 32'h0000_3100, go);
    chk("R4 goes once older stores done", go, 1);
    alloc(50, i3);
    load_q(32'h0000_0408, 46, 32'h0000_3100, go);
    chk("R4 younger store ignored", go, 1);
    load_q(32'h0000_0408, 55, 32'h0000_3100, go);
    chk("R8 bit still set before wipe", go, 0);
    wait_phase(4);
    load_q(32'h0000_0408, 55, 32'h0000_3100, go);
    chk("R8 bit cleared by periodic wipe", go, 1);
    done_st();
    @(negedge clk);

    // load record table full
    alloc(100, i0);
    for (int k = 0; k < 8; k++) begin
      load_q(32'h0000_2000 + 32'(4 * k), 101 + k, 32'h0000_0200 + 32'(16 * k), go);
      chk("R10 record fill", go, 1);
    end
    load_q(32'h0000_2100, 109, 32'h0000_0300, go);
    chk("R10 held while records full", go, 0);
    done_st();
    @(negedge clk);
    load_q(32'h0000_2104, 110, 32'h0000_0300, go);
    chk("R10 records freed after stores leave", go, 1);

    @(negedge clk);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule